// File: doc/BRIEF.md
# Victim Way Selector

This block picks the way to evict when a set-associative cache must allocate a line after a miss. For the set being filled it receives, per way, the valid, locked, use and dirty bits together with the identity of the requester. Every requester owns a way-block mask that says which ways it may evict from. The requesters are a set of cores, each with its own mask, and one class of hardware agents that all share one mask.

The result appears one cycle after the request. It is a way index with that line's dirty state, so a writeback can be started, or a "no victim" flag when no way is both permitted and unlocked. In the "no victim" case the fill goes ahead without allocating. If every candidate has been used recently, the block also asks the tag array to clear the use bits of those candidates.

Mask writes are checked before they are stored. A write that would block every way, or that names a requester that does not exist, is refused: the stored mask does not change and a reject pulse is raised. The masks affect only the choice of a victim. Hit detection and reads lie outside this block.

Top module: `victim_way_sel`

## Requirements
- R1: After reset every mask is zero, so every way is permitted. `resValid` and `maskWrReject` are low.
- R2: A request sampled with `selReq` high gives `resValid` high in the next cycle only. A cycle without a request gives `resValid` low in the next cycle.
- R3: Mask bit i governs way i. A 1 forbids the requester from evicting that way and a 0 permits it. Requester ids 0 to NUM_CORES-1 are cores, each with its own mask. Id NUM_CORES is the hardware-agent class, whose single mask is separate from all core masks.
- R4: A way whose lock bit is set is never reported as the victim.
- R5: A candidate is a way that is both permitted and unlocked. When any candidate is invalid, the lowest-index invalid candidate is chosen.
- R6: When every candidate is valid, the lowest-index candidate whose use bit is 0 is chosen.
- R7: When every candidate has its use bit set, the lowest-index candidate is chosen. In the same cycle `useClrEn` is 1 and `useClrMask` holds exactly the candidate set. In all other results `useClrEn` is 0 and `useClrMask` is 0.
- R8: With no candidate, `resNoVictim` is 1, while `resWay`, `resDirty` and `useClrEn` are 0.
- R9: `resDirty` is the chosen way's dirty bit ANDed with its valid bit.
- R10: A mask write whose data is all ones is refused. `maskWrReject` is 1 in the next cycle and the stored mask does not change. An accepted write is used by requests from the next cycle on. A request in the same cycle as a write uses the old mask.
- R11: A mask write to an id above NUM_CORES is refused in the same way. A request from such an id gets `resNoVictim`.
- R12: A way blocked in every requester's mask is never chosen, whatever the lock, use and valid bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrId | input | REQ_W | Requester whose mask is written |
| maskWrData | input | NUM_WAYS | New block mask (1 = forbidden) |
| maskWrReject | output | 1 | Pulse: the previous cycle's write was refused |
| selReq | input | 1 | Victim selection request |
| selReqId | input | REQ_W | Requesting core or agent class |
| selValid | input | NUM_WAYS | Per-way valid bits of the set |
| selLock | input | NUM_WAYS | Per-way lock bits |
| selUse | input | NUM_WAYS | Per-way recently-used bits |
| selDirty | input | NUM_WAYS | Per-way dirty bits |
| resValid | output | 1 | Result valid |
| resNoVictim | output | 1 | No evictable way |
| resWay | output | WAY_W | Chosen victim way |
| resDirty | output | 1 | Chosen line needs writeback |
| useClrEn | output | 1 | Clear use bits of the set |
| useClrMask | output | NUM_WAYS | Ways whose use bits are cleared |

## Verification
The block stores nothing except the masks and the output register. A wrong mask entry therefore shows up at the first request from that requester that lands on the affected way, one cycle after that request. This can be a forbidden way being reported, or a spurious "no victim". A write that is wrongly accepted or refused is caught by the reject pulse in the very next cycle. It is also caught later by the victims chosen for that requester, which the bench compares against a mask model of its own. Random requests interleaved with mask writes, including all-ones and out-of-range writes, expose priority and mask errors within a few cycles of the pattern that triggers them.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic wrAccept;
    logic wrReject;
    logic selFire;
    logic selIdOk;
  } vselCtrl_t;

  typedef enum logic [1:0] {
    PICK_NONE    = 2'd0,
    PICK_INVALID = 2'd1,
    PICK_FRESH   = 2'd2,
    PICK_AGED    = 2'd3
  } pickKind_e;

endpackage

// File: rtl/vsel_ctrl.sv
module vsel_ctrl
  import vsel_pkg::*;
#(
  parameter int unsigned NUM_WAYS  = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned REQ_W     = $clog2(NUM_CORES + 1)
) (
  input  logic                maskWrEn,
  input  logic [REQ_W-1:0]    maskWrId,
  input  logic [NUM_WAYS-1:0] maskWrData,
  input  logic                selReq,
  input  logic [REQ_W-1:0]    selReqId,
  output vselCtrl_t           ctrl
);

  localparam logic [REQ_W:0] NUM_REQ_V = (REQ_W + 1)'(NUM_CORES + 1);

  logic wrIdOk;
  logic wrAllBlocked;
  logic wrLegal;

  always_comb begin
    wrIdOk       = {1'b0, maskWrId} < NUM_REQ_V;
    wrAllBlocked = &maskWrData;
    wrLegal      = wrIdOk & ~wrAllBlocked;
    ctrl.wrAccept = maskWrEn & wrLegal;
    ctrl.wrReject = maskWrEn & ~wrLegal;
    ctrl.selFire  = selReq;
    ctrl.selIdOk  = {1'b0, selReqId} < NUM_REQ_V;
  end

endmodule

// File: rtl/vsel_datapath.sv
module vsel_datapath
  import vsel_pkg::*;
#(
  parameter int unsigned NUM_WAYS  = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned REQ_W     = $clog2(NUM_CORES + 1),
  parameter int unsigned WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  vselCtrl_t           ctrl,
  input  logic [REQ_W-1:0]    maskWrId,
  input  logic [NUM_WAYS-1:0] maskWrData,
  input  logic [REQ_W-1:0]    selReqId,
  input  logic [NUM_WAYS-1:0] selValid,
  input  logic [NUM_WAYS-1:0] selLock,
  input  logic [NUM_WAYS-1:0] selUse,
  input  logic [NUM_WAYS-1:0] selDirty,
  output logic                resValid,
  output logic                resNoVictim,
  output logic [WAY_W-1:0]    resWay,
  output logic                resDirty,
  output logic                useClrEn,
  output logic [NUM_WAYS-1:0] useClrMask,
  output logic                maskWrReject
);

  localparam int unsigned NUM_REQ = NUM_CORES + 1;

  logic [NUM_WAYS-1:0] maskMem [NUM_REQ];

  // one block mask per requester; last entry is the shared agent mask
  for (genvar r = 0; r < NUM_REQ; r++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskMem[r] <= '0;
      end else if (ctrl.wrAccept && (maskWrId == REQ_W'(r))) begin
        maskMem[r] <= maskWrData;
      end
    end
  end

  function automatic logic [WAY_W-1:0] lowestIdx(input logic [NUM_WAYS-1:0] vec);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (vec[i]) idx = WAY_W'(i);
    end
    return idx;
  endfunction

  logic [NUM_WAYS-1:0] reqMask;
  logic [NUM_WAYS-1:0] candSet;
  logic [NUM_WAYS-1:0] invSet;
  logic [NUM_WAYS-1:0] freshSet;
  pickKind_e           pickKind;
  logic [WAY_W-1:0]    pickWay;
  logic                pickDirty;

  always_comb begin
    reqMask = '1;
    if (ctrl.selIdOk) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (selReqId == REQ_W'(r)) reqMask = maskMem[r];
      end
    end
    candSet  = ~reqMask & ~selLock;
    invSet   = candSet & ~selValid;
    freshSet = candSet & ~selUse;

    if (candSet == '0) begin
      pickKind = PICK_NONE;
      pickWay  = '0;
    end else if (invSet != '0) begin
      pickKind = PICK_INVALID;
      pickWay  = lowestIdx(invSet);
    end else if (freshSet != '0) begin
      pickKind = PICK_FRESH;
      pickWay  = lowestIdx(freshSet);
    end else begin
      pickKind = PICK_AGED;
      pickWay  = lowestIdx(candSet);
    end
    pickDirty = (pickKind != PICK_NONE) & selDirty[pickWay] & selValid[pickWay];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid     <= 1'b0;
      resNoVictim  <= 1'b0;
      resWay       <= '0;
      resDirty     <= 1'b0;
      useClrEn     <= 1'b0;
      useClrMask   <= '0;
      maskWrReject <= 1'b0;
    end else begin
      maskWrReject <= ctrl.wrReject;
      resValid     <= ctrl.selFire;
      if (ctrl.selFire) begin
        resNoVictim <= (pickKind == PICK_NONE);
        resWay      <= pickWay;
        resDirty    <= pickDirty;
        useClrEn    <= (pickKind == PICK_AGED);
        useClrMask  <= (pickKind == PICK_AGED) ? candSet : '0;
      end else begin
        resNoVictim <= 1'b0;
        resWay      <= '0;
        resDirty    <= 1'b0;
        useClrEn    <= 1'b0;
        useClrMask  <= '0;
      end
    end
  end

endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel
  import vsel_pkg::*;
#(
  parameter int unsigned NUM_WAYS  = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned REQ_W     = $clog2(NUM_CORES + 1),
  parameter int unsigned WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                maskWrEn,
  input  logic [REQ_W-1:0]    maskWrId,
  input  logic [NUM_WAYS-1:0] maskWrData,
  output logic                maskWrReject,
  input  logic                selReq,
  input  logic [REQ_W-1:0]    selReqId,
  input  logic [NUM_WAYS-1:0] selValid,
  input  logic [NUM_WAYS-1:0] selLock,
  input  logic [NUM_WAYS-1:0] selUse,
  input  logic [NUM_WAYS-1:0] selDirty,
  output logic                resValid,
  output logic                resNoVictim,
  output logic [WAY_W-1:0]    resWay,
  output logic                resDirty,
  output logic                useClrEn,
  output logic [NUM_WAYS-1:0] useClrMask
);

  vselCtrl_t ctrl;

  vsel_ctrl #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_CORES(NUM_CORES),
    .REQ_W    (REQ_W)
  ) ctrl_i (
    .maskWrEn  (maskWrEn),
    .maskWrId  (maskWrId),
    .maskWrData(maskWrData),
    .selReq    (selReq),
    .selReqId  (selReqId),
    .ctrl      (ctrl)
  );

  vsel_datapath #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_CORES(NUM_CORES),
    .REQ_W    (REQ_W),
    .WAY_W    (WAY_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .maskWrId    (maskWrId),
    .maskWrData  (maskWrData),
    .selReqId    (selReqId),
    .selValid    (selValid),
    .selLock     (selLock),
    .selUse      (selUse),
    .selDirty    (selDirty),
    .resValid    (resValid),
    .resNoVictim (resNoVictim),
    .resWay      (resWay),
    .resDirty    (resDirty),
    .useClrEn    (useClrEn),
    .useClrMask  (useClrMask),
    .maskWrReject(maskWrReject)
  );

endmodule

// File: rtl/victim_way_sel_chk.sv
module victim_way_sel_chk #(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned WAY_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                maskWrEn,
  input logic [NUM_WAYS-1:0] maskWrData,
  input logic                maskWrReject,
  input logic                selReq,
  input logic [NUM_WAYS-1:0] selValid,
  input logic [NUM_WAYS-1:0] selLock,
  input logic [NUM_WAYS-1:0] selUse,
  input logic [NUM_WAYS-1:0] selDirty,
  input logic                resValid,
  input logic                resNoVictim,
  input logic [WAY_W-1:0]    resWay,
  input logic                resDirty,
  input logic                useClrEn,
  input logic [NUM_WAYS-1:0] useClrMask
);

  logic [NUM_WAYS-1:0] lockQ, validQ, useQ, dirtyQ;

  always_ff @(posedge clk) begin
    lockQ  <= selLock;
    validQ <= selValid;
    useQ   <= selUse;
    dirtyQ <= selDirty;
  end

  p_lat_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    selReq |=> resValid);

  p_lat_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !selReq |=> !resValid);

  p_no_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resNoVictim && $past(rstN)) |-> !lockQ[resWay]);

  p_clear_aged_r7: assert property (@(posedge clk) disable iff (!rstN)
    useClrEn |-> (resValid && !resNoVictim && useClrMask[resWay]
                  && ((useClrMask & ~useQ) == '0)));

  p_none_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resNoVictim) |-> (!resDirty && !useClrEn && resWay == '0));

  p_dirty_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resDirty && $past(rstN)) |-> (resValid && validQ[resWay] && dirtyQ[resWay]));

  p_reject_full_r10: assert property (@(posedge clk) disable iff (!rstN)
    (maskWrEn && (&maskWrData)) |=> maskWrReject);

endmodule

bind victim_way_sel victim_way_sel_chk #(
  .NUM_WAYS(NUM_WAYS),
  .WAY_W   (WAY_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .maskWrEn    (maskWrEn),
  .maskWrData  (maskWrData),
  .maskWrReject(maskWrReject),
  .selReq      (selReq),
  .selValid    (selValid),
  .selLock     (selLock),
  .selUse      (selUse),
  .selDirty    (selDirty),
  .resValid    (resValid),
  .resNoVictim (resNoVictim),
  .resWay      (resWay),
  .resDirty    (resDirty),
  .useClrEn    (useClrEn),
  .useClrMask  (useClrMask)
);

// File: tb/victim_way_sel_tb_top.sv
`timescale 1ns/1ps
module victim_way_sel_tb_top;

  localparam int NW = 8;
  localparam int NC = 4;
  localparam int RW = 3;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          maskWrEn = 1'b0;
  logic [RW-1:0] maskWrId = '0;
  logic [NW-1:0] maskWrData = '0;
  logic          maskWrReject;
  logic          selReq = 1'b0;
  logic [RW-1:0] selReqId = '0;
  logic [NW-1:0] selValid = '0, selLock = '0, selUse = '0, selDirty = '0;
  logic          resValid, resNoVictim, resDirty, useClrEn;
  logic [WW-1:0] resWay;
  logic [NW-1:0] useClrMask;

  always #10 clk = ~clk;

  victim_way_sel #(.NUM_WAYS(NW), .NUM_CORES(NC)) dut_i (
    .clk(clk), .rstN(rstN),
    .maskWrEn(maskWrEn), .maskWrId(maskWrId), .maskWrData(maskWrData),
    .maskWrReject(maskWrReject),
    .selReq(selReq), .selReqId(selReqId), .selValid(selValid),
    .selLock(selLock), .selUse(selUse), .selDirty(selDirty),
    .resValid(resValid), .resNoVictim(resNoVictim), .resWay(resWay),
    .resDirty(resDirty), .useClrEn(useClrEn), .useClrMask(useClrMask)
  );

  typedef struct {
    logic          nv;
    logic [WW-1:0] way;
    logic          dirty;
    logic          clr;
    logic [NW-1:0] clrMask;
    string         tag;
  } exp_t;

  exp_t          expQ[$];
  logic [NW-1:0] mdlMask [NC+1];
  int            nChecks = 0;
  int            nFails  = 0;
  bit            monOn   = 1'b0;
  bit            finished = 1'b0;

  function automatic exp_t model(input logic [RW-1:0] id, input logic [NW-1:0] v,
                                 input logic [NW-1:0] l, input logic [NW-1:0] u,
                                 input logic [NW-1:0] d, input string tag);
    exp_t e;
    logic [NW-1:0] m, c, pick;
    int w;
    m = (int'(id) <= NC) ? mdlMask[id] : '1;
    c = ~m & ~l;
    e.nv = (c == '0); e.way = '0; e.dirty = 1'b0; e.clr = 1'b0; e.clrMask = '0; e.tag = tag;
    if (c != '0) begin
      if ((c & ~v) != '0)      pick = c & ~v;
      else if ((c & ~u) != '0) pick = c & ~u;
      else begin
        pick = c; e.clr = 1'b1; e.clrMask = c;
      end
      w = -1;
      for (int i = NW - 1; i >= 0; i--) if (pick[i]) w = i;
      e.way = WW'(w);
      e.dirty = v[w] & d[w];
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string what, input string got, input string exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %s expected %s", what, got, exp);
    end
  endtask

  task automatic doSel(input logic [RW-1:0] id, input logic [NW-1:0] v, input logic [NW-1:0] l,
                       input logic [NW-1:0] u, input logic [NW-1:0] d, input string tag);
    @(negedge clk);
    maskWrEn = 1'b0;
    selReq = 1'b1; selReqId = id; selValid = v; selLock = l; selUse = u; selDirty = d;
    expQ.push_back(model(id, v, l, u, d, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      selReq = 1'b0; maskWrEn = 1'b0;
    end
  endtask

  task automatic doWr(input logic [RW-1:0] id, input logic [NW-1:0] data, input string tag);
    bit rej;
    rej = (int'(id) > NC) || (&data);
    @(negedge clk);
    selReq = 1'b0;
    maskWrEn = 1'b1; maskWrId = id; maskWrData = data;
    if (!rej) mdlMask[id] = data;
    @(negedge clk);
    maskWrEn = 1'b0;
    check(maskWrReject == rej, {tag, " reject flag"},
          $sformatf("%0b", maskWrReject), $sformatf("%0b", rej));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (monOn && resValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected result", "resValid=1", "no result");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(resNoVictim == e.nv && (e.nv || resWay == e.way) && resDirty == e.dirty
              && useClrEn == e.clr && useClrMask == e.clrMask, e.tag,
              $sformatf("nv=%0b way=%0d dirty=%0b clr=%0b/%h",
                        resNoVictim, resWay, resDirty, useClrEn, useClrMask),
              $sformatf("nv=%0b way=%0d dirty=%0b clr=%0b/%h",
                        e.nv, e.way, e.dirty, e.clr, e.clrMask));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r <= NC; r++) mdlMask[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: outputs quiet after reset
    check(!resValid && !maskWrReject, "R1 reset outputs",
          $sformatf("%0b%0b", resValid, maskWrReject), "00");
    monOn = 1'b1;

    // R1: zero masks permit way 0 for every requester
    doSel(0, 8'hFF, 8'h00, 8'h00, 8'h00, "R1 core0 default");
    doSel(NC, 8'hFF, 8'h00, 8'h00, 8'h00, "R1 agent default");
    // R5: invalid first, lowest index
    doSel(1, 8'b1010_1111, 8'h00, 8'h00, 8'hFF, "R5 invalid pick");
    // R4 R6: lowest unused unlocked
    doSel(2, 8'hFF, 8'b0000_0011, 8'b0001_0100, 8'hFF, "R6 fresh pick");
    // R7: all candidates used
    doSel(3, 8'hFF, 8'b0000_0101, 8'hFF, 8'h00, "R7 aged pick");
    // R8: everything locked
    doSel(0, 8'hFF, 8'hFF, 8'h00, 8'h00, "R8 all locked");
    // R9: dirty on valid line, and dirty ignored on invalid line
    doSel(0, 8'hFF, 8'h00, 8'h01, 8'b0000_0010, "R9 dirty victim");
    doSel(0, 8'hFE, 8'h00, 8'h00, 8'h01, "R9 invalid not dirty");
    idle(2);

    // R3: per-core masks and separate agent mask
    doWr(0, 8'h0F, "R3 core0 write");
    doWr(NC, 8'hF0, "R3 agent write");
    doSel(0, 8'hFF, 8'h00, 8'h00, 8'hFF, "R3 core0 masked");
    doSel(NC, 8'hFF, 8'h00, 8'h00, 8'h00, "R3 agent masked");
    doSel(1, 8'hFF, 8'h00, 8'h00, 8'h00, "R3 core1 unaffected");
    doSel(0, 8'hFF, 8'h10, 8'hFF, 8'h00, "R7 masked aged");
    doSel(0, 8'hFF, 8'hF0, 8'h00, 8'h00, "R8 mask plus lock");
    idle(2);

    // R10: all-ones write refused, old mask kept
    doWr(0, 8'hFF, "R10 all-ones write");
    doSel(0, 8'hFF, 8'h00, 8'h00, 8'h00, "R10 old mask kept");
    idle(2);
    // R10: same-cycle request sees old mask, next cycle sees new
    @(negedge clk);
    maskWrEn = 1'b1; maskWrId = 1; maskWrData = 8'h07;
    selReq = 1'b1; selReqId = 1; selValid = 8'hFF; selLock = '0; selUse = '0; selDirty = '0;
    expQ.push_back(model(1, 8'hFF, '0, '0, '0, "R10 same-cycle old mask"));
    mdlMask[1] = 8'h07;
    @(negedge clk);
    maskWrEn = 1'b0;
    check(!maskWrReject, "R10 accepted write flag", $sformatf("%0b", maskWrReject), "0");
    selReq = 1'b1; selReqId = 1;
    expQ.push_back(model(1, 8'hFF, '0, '0, '0, "R10 next-cycle new mask"));
    idle(2);

    // R11: out-of-range id
    doWr(RW'(NC + 1), 8'h00, "R11 bad id write");
    doSel(RW'(NC + 2), 8'h00, 8'h00, 8'h00, 8'h00, "R11 bad id request");
    idle(2);

    // R12: way 7 blocked in every mask
    for (int r = 0; r <= NC; r++) doWr(RW'(r), 8'h80, "R12 block way7");
    for (int i = 0; i < 200; i++) begin
      logic [NW-1:0] lk;
      lk = NW'($urandom) | 8'h3F;
      doSel(RW'($urandom_range(0, NC)), NW'($urandom), lk, NW'($urandom), NW'($urandom),
            "R12 never way7");
    end
    idle(2);

    // mixed random traffic: R3 R4 R5 R6 R7 R10 R11
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        logic [NW-1:0] md;
        md = ($urandom_range(0, 3) == 0) ? '1 : NW'($urandom);
        doWr(RW'($urandom), md, "R10 random write");
      end else begin
        doSel(RW'($urandom), NW'($urandom), NW'($urandom) & NW'($urandom),
              NW'($urandom), NW'($urandom), "R4 random select");
      end
    end
    idle(3);
    check(expQ.size() == 0, "R2 all results seen",
          $sformatf("%0d pending", expQ.size()), "0 pending");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule